// File: doc/BRIEF.md
# Flash Checksum Read Engine

This block walks a region of flash through the read path and, instead of writing the data anywhere, folds every 32-bit word it receives into a running 32-bit sum. Software uses it to check read timing. It first takes a reference sum at a slow, safe setting. It then repeats the pass at faster clock and sampling settings and compares each result with the reference. A typical pass covers 1 KiB (0x400 bytes) starting 64 KiB (0x10000) into the first device window.

Software programs it through five word registers: control, flash start address, byte length, result and status. A pass starts when a control word with both the enable and the checksum bits set is written while the engine is idle. The engine issues one read request per word and holds each request and its address until the flash side acknowledges it. When the pass ends it raises a completion flag. When the calibration bit is set, the engine drives the clock divider and input-sampling delay codes taken from its own control word onto the read path for the length of the pass. At all other times the normal settings pass through unchanged.

Top module: `csdma_top`

## Requirements
- R1: Register offsets are 0 control, 1 flash start address, 2 byte length, 3 result (read-only), 4 status. Control bit 0 is enable, bit 1 is direction, bit 2 is checksum mode and bit 3 is calibration mode. A control write while idle starts a pass only when bits 0 and 2 are both 1. The direction bit is stored and read back, and has no effect on the pass. Without bits 0 and 2 set, no read request is issued.
- R2: A pass reads consecutive 32-bit words. The first address is the start address, and each later address is 4 above the one before. rd_req_o and rd_addr_o hold steady until rd_ack_i is high at a clock edge.
- R3: The result register holds the 32-bit wrapping sum of all acknowledged words of the pass. It is zeroed when the pass starts.
- R4: The length register counts bytes, and its two low bits are ignored. A length below 4 completes with a sum of 0 and issues no read.
- R5: Status bit 11 (also output done_o) is set when a pass completes. A status write with bit 11 equal to 0 clears it. A status write with bit 11 equal to 1 leaves it unchanged.
- R6: During a pass with control bit 3 set, eff_div_o equals control bits [7:4] and eff_delay_o equals control bits [11:8]. At all other times they equal base_div_i and base_delay_i.
- R7: A nonzero control write during a pass is ignored. The control readback is unchanged, the override outputs are unchanged, and the pass finishes with the correct sum.
- R8: Writing zero to control during a pass stops it. No read request follows, and done_o is not set.
- R9: Each start write gives exactly one pass. After completion, no read request is issued until control is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr |
| base_div_i | input | 4 | Normal clock divider code |
| base_delay_i | input | 4 | Normal input-delay code |
| eff_div_o | output | 4 | Divider code applied to the read path |
| eff_delay_o | output | 4 | Input-delay code applied to the read path |
| rd_req_o | output | 1 | Flash word read request |
| rd_addr_o | output | 28 | Flash byte address of the requested word |
| rd_ack_i | input | 1 | Request accepted, data valid |
| rd_data_i | input | 32 | Read word |
| done_o | output | 1 | Completion flag (status bit 11) |

## Verification
The hardest situations to reach are control writes that land in the middle of a pass. A nonzero rewrite must leave the pass and the override codes alone, while a zero write must cut the pass short without raising completion. The flash model stalls three acknowledges out of every four, so a pass of many words stays busy long enough for these writes to arrive between accepted reads. Each word is a hash of its address, so a skipped, repeated or misplaced read changes the sum.

// File: rtl/csdma_pkg.sv
package csdma_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned FW = 4;
  localparam logic [2:0] OFS_CTL  = 3'd0;
  localparam logic [2:0] OFS_SRC  = 3'd1;
  localparam logic [2:0] OFS_LEN  = 3'd2;
  localparam logic [2:0] OFS_SUM  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;
  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_CK     = 2;
  localparam int unsigned B_CAL    = 3;
  localparam int unsigned DIV_LSB  = 4;
  localparam int unsigned DLY_LSB  = 8;
  localparam int unsigned DONE_BIT = 11;
  typedef enum logic {W_IDLE, W_BUSY} walk_st_e;
endpackage

// File: rtl/csdma_regs.sv
module csdma_regs
  import csdma_pkg::*;
#(
  parameter int unsigned AW = 28,
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          fin,
  input  logic [DW-1:0] sum,
  output logic          cal_o,
  output logic [FW-1:0] div_o,
  output logic [FW-1:0] dly_o,
  output logic [AW-1:0] src_o,
  output logic [LW-3:0] nwords_o,
  output logic          start_o,
  output logic          abort_o,
  output logic          done_o
);
  logic [DW-1:0] ctl_q, ctl_d;
  logic [AW-1:0] src_q, src_d;
  logic [LW-1:0] len_q, len_d;
  logic          done_q, done_d;
  logic          ctl_en, src_en, len_en, done_en;
  logic          ctl_wr, stat_wr;

  always_comb begin
    ctl_wr  = we && (addr == OFS_CTL);
    stat_wr = we && (addr == OFS_STAT);
    start_o = ctl_wr && !busy && wdata[B_EN] && wdata[B_CK];
    abort_o = ctl_wr && busy && (wdata == '0);
    ctl_en  = ctl_wr && (!busy || (wdata == '0));
    ctl_d   = wdata;
    src_en  = we && (addr == OFS_SRC);
    src_d   = wdata[AW-1:0];
    len_en  = we && (addr == OFS_LEN);
    len_d   = wdata[LW-1:0];
    done_en = fin || (stat_wr && !wdata[DONE_BIT]);
    done_d  = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      src_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_d;
      if (src_en)  src_q  <= src_d;
      if (len_en)  len_q  <= len_d;
      if (done_en) done_q <= done_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTL:  rdata = ctl_q;
      OFS_SRC:  rdata = DW'(src_q);
      OFS_LEN:  rdata = DW'(len_q);
      OFS_SUM:  rdata = sum;
      OFS_STAT: rdata = DW'({done_q, {DONE_BIT{1'b0}}});
      default:  rdata = '0;
    endcase
  end

  assign cal_o    = ctl_q[B_CAL];
  assign div_o    = ctl_q[DIV_LSB +: FW];
  assign dly_o    = ctl_q[DLY_LSB +: FW];
  assign src_o    = src_q;
  assign nwords_o = len_q[LW-1:2];
  assign done_o   = done_q;

  assert_ctl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr && (wdata != '0)) |=> $stable(ctl_q));
endmodule

// File: rtl/csdma_walker.sv
module csdma_walker
  import csdma_pkg::*;
#(
  parameter int unsigned AW = 28,
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] src_i,
  input  logic [LW-3:0] nwords_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic [DW-1:0] sum_o
);
  localparam int unsigned NW = LW - 2;

  walk_st_e      st_q, st_d;
  logic [NW-1:0] rem_q, rem_d;
  logic [AW-1:0] adr_q, adr_d;
  logic [DW-1:0] sum_q, sum_d;
  logic          upd_en;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    adr_d  = adr_q;
    sum_d  = sum_q;
    upd_en = 1'b0;
    fin_o  = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (start_i) begin
          st_d   = W_BUSY;
          rem_d  = nwords_i;
          adr_d  = src_i;
          sum_d  = '0;
          upd_en = 1'b1;
        end
      end
      default: begin
        if (abort_i) begin
          st_d   = W_IDLE;
          upd_en = 1'b1;
        end else if (rem_q == '0) begin
          st_d   = W_IDLE;
          fin_o  = 1'b1;
          upd_en = 1'b1;
        end else if (rd_ack_i) begin
          rem_d  = rem_q - NW'(1);
          adr_d  = adr_q + AW'(4);
          sum_d  = sum_q + rd_data_i;
          upd_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      rem_q <= '0;
      adr_q <= '0;
      sum_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      rem_q <= rem_d;
      adr_q <= adr_d;
      sum_q <= sum_d;
    end
  end

  assign busy_o    = (st_q == W_BUSY);
  assign rd_req_o  = busy_o && (rem_q != '0);
  assign rd_addr_o = adr_q;
  assign sum_o     = sum_q;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i && !abort_i) |=> (rd_req_o && $stable(rd_addr_o)));
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_ack_i && !abort_i) |=> (rd_addr_o == $past(rd_addr_o) + AW'(4)));
  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !rd_req_o);
endmodule

// File: rtl/csdma_tmux.sv
module csdma_tmux
  import csdma_pkg::*;
(
  input  logic          busy_i,
  input  logic          cal_i,
  input  logic [FW-1:0] cal_div_i,
  input  logic [FW-1:0] cal_dly_i,
  input  logic [FW-1:0] base_div_i,
  input  logic [FW-1:0] base_dly_i,
  output logic [FW-1:0] eff_div_o,
  output logic [FW-1:0] eff_dly_o
);
  logic use_cal;
  always_comb begin
    use_cal   = busy_i && cal_i;
    eff_div_o = use_cal ? cal_div_i : base_div_i;
    eff_dly_o = use_cal ? cal_dly_i : base_dly_i;
  end
endmodule

// File: rtl/csdma_top.sv
module csdma_top
  import csdma_pkg::*;
#(
  parameter int unsigned AW = 28,
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [3:0]    base_div_i,
  input  logic [3:0]    base_delay_i,
  output logic [3:0]    eff_div_o,
  output logic [3:0]    eff_delay_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [31:0]   rd_data_i,
  output logic          done_o
);
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic          busy, fin, start, abort, cal;
  logic [DW-1:0] sum;
  logic [FW-1:0] cdiv, cdly;
  logic [AW-1:0] src;
  logic [LW-3:0] nwords;

  csdma_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(srst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .fin(fin), .sum(sum), .cal_o(cal),
    .div_o(cdiv), .dly_o(cdly), .src_o(src), .nwords_o(nwords),
    .start_o(start), .abort_o(abort), .done_o(done_o)
  );

  csdma_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(srst_n), .start_i(start), .abort_i(abort), .src_i(src),
    .nwords_i(nwords), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy), .fin_o(fin),
    .sum_o(sum)
  );

  csdma_tmux u_tmux (
    .busy_i(busy), .cal_i(cal), .cal_div_i(cdiv), .cal_dly_i(cdly),
    .base_div_i(base_div_i), .base_dly_i(base_delay_i),
    .eff_div_o(eff_div_o), .eff_dly_o(eff_delay_o)
  );

  assert_done_after_pass_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(done_o) |-> $past(busy));
  assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !busy |-> !rd_req_o);
endmodule

// File: tb/csdma_top_tb_top.sv
`timescale 1ns/1ps
module csdma_top_tb_top;
  localparam int AW = 28;
  localparam logic [31:0] BDIV = 32'h3, BDLY = 32'h1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd3;
  logic [31:0] reg_wdata = '0, reg_rdata, rd_data_i;
  logic [3:0] eff_div_o, eff_delay_o;
  logic rd_req_o, rd_ack_i, done_o;
  logic [AW-1:0] rd_addr_o;
  logic [1:0] ph = 2'd0;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  csdma_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_div_i(BDIV[3:0]),
    .base_delay_i(BDLY[3:0]), .eff_div_o(eff_div_o), .eff_delay_o(eff_delay_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .done_o(done_o)
  );

  function automatic logic [31:0] fword(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h00C0FFEE;
  endfunction

  function automatic logic [31:0] exp_sum(logic [31:0] src, logic [31:0] len);
    logic [31:0] s = '0;
    for (int i = 0; i < int'(len >> 2); i++) s += fword(src + 32'(4 * i));
    return s;
  endfunction

  assign rd_data_i = fword({{(32-AW){1'b0}}, rd_addr_o});
  assign rd_ack_i  = rd_req_o && (ph == 2'd3);
  always @(negedge clk) begin
    ph <= ph + 2'd1;
    cyc <= cyc + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd3;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 3'd3;
  endtask

  task automatic wait_done(string tag);
    int k = 0;
    while (!done_o && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(tag, {31'd0, done_o}, 32'd1);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(logic [31:0] src, logic [31:0] len, logic [31:0] ctl, string tag);
    logic [31:0] v;
    wr(3'd1, src);
    wr(3'd2, len);
    exp_q.push_back(exp_sum(src, len));
    wr(3'd0, ctl);
    wait_done(tag);
    rd(3'd4, v);
    chk({tag, " status bit11"}, v, 32'h800);
    wr(3'd4, 32'h0);
  endtask

  // monitor: scoreboard compare of result register at completion (R3)
  always @(posedge done_o) begin
    @(negedge clk);
    if (exp_q.size() == 0) chk("R3 unexpected completion", reg_rdata, 32'hx);
    else chk("R3 result sum", reg_rdata, exp_q.pop_front());
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // reset state
    chk("R5 reset done", {31'd0, done_o}, 32'd0);
    chk("R1 reset req", {31'd0, rd_req_o}, 32'd0);
    chk("R3 reset result", reg_rdata, 32'd0);
    chk("R6 reset div", {28'd0, eff_div_o}, BDIV);

    // R2/R3 basic pass
    run(32'h0000_0100, 32'd16, 32'h5, "R2 basic");
    // R1 direction bit stored, no effect
    run(32'h0000_2000, 32'd40, 32'h7, "R1 dir bit");
    rd(3'd0, v);
    chk("R1 ctl readback", v, 32'h7);
    // R4 remainder ignored and zero length
    run(32'h0000_0300, 32'h13, 32'h5, "R4 remainder");
    run(32'h0000_0400, 32'h3, 32'h5, "R4 short length");

    // R6 calibration pass, typical region
    wr(3'd1, 32'h0001_0000);
    wr(3'd2, 32'h400);
    exp_q.push_back(exp_sum(32'h0001_0000, 32'h400));
    wr(3'd0, 32'hA5D);
    chk("R6 cal div", {28'd0, eff_div_o}, 32'h5);
    chk("R6 cal delay", {28'd0, eff_delay_o}, 32'hA);
    idle(100);
    chk("R6 cal div mid", {28'd0, eff_div_o}, 32'h5);
    wait_done("R6 cal pass");
    chk("R6 div restored", {28'd0, eff_div_o}, BDIV);
    chk("R6 delay restored", {28'd0, eff_delay_o}, BDLY);
    // R5 write with bit11 set keeps, zero clears
    wr(3'd4, 32'h800);
    chk("R5 keep", {31'd0, done_o}, 32'd1);
    wr(3'd4, 32'h0);
    chk("R5 clear", {31'd0, done_o}, 32'd0);

    // R9 no second pass without a new write
    idle(20);
    chk("R9 no req", {31'd0, rd_req_o}, 32'd0);
    chk("R9 no done", {31'd0, done_o}, 32'd0);

    // R7 nonzero write during pass ignored
    wr(3'd1, 32'h0000_5000);
    wr(3'd2, 32'd64);
    exp_q.push_back(exp_sum(32'h0000_5000, 32'd64));
    wr(3'd0, 32'h5);
    idle(5);
    wr(3'd0, 32'hA5D);
    chk("R7 div unchanged", {28'd0, eff_div_o}, BDIV);
    rd(3'd0, v);
    chk("R7 ctl unchanged", v, 32'h5);
    wait_done("R7 pass completes");
    wr(3'd4, 32'h0);

    // R8 zero write aborts
    wr(3'd1, 32'h0000_6000);
    wr(3'd2, 32'h100);
    wr(3'd0, 32'h5);
    idle(10);
    wr(3'd0, 32'h0);
    chk("R8 req stopped", {31'd0, rd_req_o}, 32'd0);
    idle(300);
    chk("R8 no done", {31'd0, done_o}, 32'd0);
    // R1 enable without checksum bit: no pass
    wr(3'd0, 32'h1);
    idle(10);
    chk("R1 no checksum no req", {31'd0, rd_req_o}, 32'd0);
    chk("R1 no checksum no done", {31'd0, done_o}, 32'd0);
    // pass after abort
    run(32'h0000_7000, 32'd32, 32'h5, "R8 pass after abort");

    idle(5);
    chk("R3 all results consumed", exp_q.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule